// File: doc/BRIEF.md
# Byte-Banked Interrupt Request Combiner

The block gathers a set of external interrupt request lines, by default 24, into byte-wide banks and presents them to a host processor as one combined interrupt line. Each bank has a status register and an enable register, both reached over a small byte-wide register bus. Every input first passes through a two-flop synchronizer.

All inputs but one are edge sources. A rising edge is latched only while the source's enable bit is set. An edge that arrives while the source is disabled is dropped. A request that is raised and held while disabled therefore stays lost, even after it is enabled again. Latched edges clear as a side effect of reading the bank's status register, so the host needs no acknowledge write. The one remaining input is a level source whose status bit always shows its synchronized live value.

The combined output is high while any enabled status bit is set. The host watches it for a rising edge and then reads the banks to find the cause.

Top module: `irqc_top`

## Requirements
- R1: After reset all enable registers, all latched status bits, `reg_rdata` and `irq_o` are 0.
- R2: Byte offsets 3, 4 and 5 are the read/write enable registers of banks 0, 1 and 2. Offsets 0, 1 and 2 are the read-only status registers of the same banks, and writes to them have no effect. Offsets 6 and 7 read as 0. A read strobe in one cycle loads `reg_rdata` at that clock edge, and `reg_rdata` holds the value until the next read.
- R3: Source n appears in bank n/8 at bit n%8, in both the status and the enable register.
- R4: For an edge source with its enable bit at 1, a rising input is latched into its status bit. The bit is set at the third clock edge after the input changes: two edges for synchronization and one for capture.
- R5: An edge source whose enable bit is 0 latches nothing. A request raised while disabled and still held when the bit is set to 1 is not latched.
- R6: A read of status offset b returns the value before the clear and clears the latched edges of bank b only. Other banks keep their bits.
- R7: If a new edge is captured in the same cycle as a status read of its bank, that edge stays latched after the clear.
- R8: The level source (index `LEVEL_SRC`, default 10, which is bank 1 bit 2) shows its synchronized input in its status bit. Its enable bit and status reads have no effect on this bit.
- R9: `irq_o` is the OR over all banks of status AND enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 24 | Interrupt request lines, asynchronous |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt line to the host |

## Verification
The assertions check on every cycle that a disabled edge bit never becomes set and that a read clears an edge bit unless a new edge arrives with it. They also check that a captured edge is always present one cycle later, that enable writes land, and that enable reads return the register. What only the bench's scenarios can show is the end-to-end behaviour. This covers the three-cycle input latency, a held request lost across unmasking, a clear that touches one bank alone, and the level source ignoring reads and its enable bit, all observed through the register bus and the combined line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_ENABLE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned WIDTH     = 8,
  parameter bit          LEVEL_EN  = 1'b0,
  parameter int unsigned LEVEL_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic             en_wr_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic             rd_clr_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] enable_o
);
  localparam logic [WIDTH-1:0] LVL_SEL = LEVEL_EN ? (WIDTH'(1) << LEVEL_BIT) : '0;

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] latch_q, latch_d;
  logic [WIDTH-1:0] enable_q, enable_d;
  logic [WIDTH-1:0] edge_w;

  // next state
  always_comb begin
    edge_w   = sync_i & ~prev_q & enable_q & ~LVL_SEL;
    latch_d  = (rd_clr_i ? '0 : latch_q) | edge_w;
    enable_d = en_wr_i ? en_wdata_i : enable_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      latch_q  <= '0;
      enable_q <= '0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= latch_d;
      if (en_wr_i) enable_q <= enable_d;
    end
  end

  assign status_o = latch_q | (sync_i & LVL_SEL);
  assign enable_o = enable_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    if (!(LEVEL_EN && i == LEVEL_BIT)) begin : g_edge
      AST_MASKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q[i] && !latch_q[i]) |=> !latch_q[i]); // R5
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !(sync_i[i] && !prev_q[i])) |=> !latch_q[i]); // R6
      AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i[i] && !prev_q[i] && enable_q[i]) |=> latch_q[i]); // R7
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned LEVEL_SRC = 10,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [BANK_W-1:0]             reg_wdata,
  output logic [BANK_W-1:0]             reg_rdata,
  output logic                          irq_o
);
  import irqc_pkg::*;

  localparam int unsigned NUM_SRC = NUM_BANKS * BANK_W;
  localparam int unsigned LVL_BNK = LEVEL_SRC / BANK_W;
  localparam int unsigned LVL_BIT = LEVEL_SRC % BANK_W;

  logic [NUM_SRC-1:0] sync_all;
  logic [BANK_W-1:0]  status_bank [NUM_BANKS];
  logic [BANK_W-1:0]  enable_bank [NUM_BANKS];
  logic [NUM_BANKS-1:0] rd_clr;
  logic [NUM_BANKS-1:0] en_wr;
  logic [BANK_W-1:0]  rdata_q, rdata_d;
  acc_kind_e          acc_kind;

  irqc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(src_i),
    .sync_o (sync_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rd_clr[b] = reg_rd && (reg_addr == ADDR_W'(b));
    assign en_wr[b]  = reg_wr && (reg_addr == ADDR_W'(NUM_BANKS + b));

    irqc_bank #(
      .WIDTH    (BANK_W),
      .LEVEL_EN (LVL_BNK == b),
      .LEVEL_BIT(LVL_BIT)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (sync_all[b*BANK_W +: BANK_W]),
      .en_wr_i   (en_wr[b]),
      .en_wdata_i(reg_wdata),
      .rd_clr_i  (rd_clr[b]),
      .status_o  (status_bank[b]),
      .enable_o  (enable_bank[b])
    );

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr[b] |=> (enable_bank[b] == $past(reg_wdata))); // R2
    AST_ENABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(NUM_BANKS + b)) |=> (reg_rdata == $past(enable_bank[b]))); // R2
  end

  // read decode
  always_comb begin
    acc_kind = ACC_NONE;
    rdata_d  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(b)) begin
        acc_kind = ACC_STATUS;
        rdata_d  = status_bank[b];
      end
      if (reg_addr == ADDR_W'(NUM_BANKS + b)) begin
        acc_kind = ACC_ENABLE;
        rdata_d  = enable_bank[b];
      end
    end
    if (acc_kind == ACC_NONE) rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  // combined line
  always_comb begin
    irq_o = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) irq_o = irq_o | (|(status_bank[b] & enable_bank[b]));
  end
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  localparam logic [23:0] LVL = 24'h000400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr),
    .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  typedef struct packed { logic [23:0] en; logic [23:0] pat; } vec_t;
  localparam vec_t VECS [6] = '{
    '{24'hFFFFFF, 24'h000001},
    '{24'hFFFFFF, 24'hA50000},
    '{24'h00FF00, 24'hFFFFFF},
    '{24'h000000, 24'h00FF00},
    '{24'h0000F0, 24'h0000FF},
    '{24'hFFFFFF, 24'h000400}
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [23:0] got, logic [23:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1; tick(); rd = 1'b0; d = rdata;
  endtask

  task automatic set_en(logic [23:0] e);
    for (int b = 0; b < 3; b++) wreg(3'(3 + b), e[b*8 +: 8]);
  endtask

  task automatic read_all(output logic [23:0] s);
    logic [7:0] d;
    for (int b = 0; b < 3; b++) begin rreg(3'(b), d); s[b*8 +: 8] = d; end
  endtask

  initial begin
    logic [23:0] s, e;
    logic [7:0]  d;
    @(negedge clk); tick(2);
    chk("R1 rdata at reset", {16'h0, rdata}, 24'h0);
    chk("R1 irq at reset", {23'h0, irq}, 24'h0);
    rst_n = 1'b1; tick(2);
    for (int b = 0; b < 3; b++) begin rreg(3'(3 + b), d); chk("R1 enable reset", {16'h0, d}, 24'h0); end
    read_all(s); chk("R1 status reset", s, 24'h0);

    // R2 register map
    wreg(3'd3, 8'h5A); wreg(3'd4, 8'hC3); wreg(3'd5, 8'h81);
    rreg(3'd3, d); chk("R2 enable bank0", {16'h0, d}, 24'h5A);
    rreg(3'd4, d); chk("R2 enable bank1", {16'h0, d}, 24'hC3);
    rreg(3'd5, d); chk("R2 enable bank2", {16'h0, d}, 24'h81);
    rreg(3'd6, d); chk("R2 offset6 zero", {16'h0, d}, 24'h0);
    wreg(3'd0, 8'hFF); tick(2);
    rreg(3'd0, d); chk("R2 status write ignored", {16'h0, d}, 24'h0);
    chk("R2 irq after status write", {23'h0, irq}, 24'h0);
    tick(1); chk("R2 rdata holds", {16'h0, rdata}, 24'h0);

    // vector table: R3 R4 R8 R9 R6
    foreach (VECS[k]) begin
      set_en(VECS[k].en); src = '0; tick(4); read_all(s);
      src = VECS[k].pat; tick(4);
      e = (VECS[k].pat & VECS[k].en & ~LVL) | (VECS[k].pat & LVL);
      chk("R9 irq vector", {23'h0, irq}, {23'h0, |(e & VECS[k].en)});
      read_all(s); chk("R3 R4 R8 status vector", s, e);
      read_all(s); chk("R6 R8 after clear", s, VECS[k].pat & LVL);
      src = '0; tick(4);
    end

    // R4 latency
    set_en(24'hFFFFFF); read_all(s);
    src = 24'h000002; tick(2);
    chk("R4 irq before third edge", {23'h0, irq}, 24'h0);
    tick(1); chk("R4 irq at third edge", {23'h0, irq}, 24'h1);
    src = '0; tick(4); read_all(s);

    // R5 held request lost across unmasking
    set_en(24'h0); src = 24'h010020; tick(4);
    set_en(24'hFFFFFF); tick(4);
    chk("R5 irq after unmask", {23'h0, irq}, 24'h0);
    read_all(s); chk("R5 held request lost", s, 24'h0);
    src = '0; tick(4);

    // R6 bank isolation
    src = 24'h400008; tick(4);
    rreg(3'd0, d); chk("R6 bank0 pre-clear", {16'h0, d}, 24'h08);
    rreg(3'd2, d); chk("R6 bank2 kept", {16'h0, d}, 24'h40);
    rreg(3'd0, d); chk("R6 bank0 cleared", {16'h0, d}, 24'h0);
    src = '0; tick(4); read_all(s);

    // R7 edge in the cycle of the read
    src = 24'h000010; tick(2);
    rreg(3'd0, d); chk("R7 read sees pre-edge", {16'h0, d}, 24'h0);
    rreg(3'd0, d); chk("R7 edge kept", {16'h0, d}, 24'h10);
    src = '0; tick(4); read_all(s);

    // R8 level ignores reads and enable, follows release
    set_en(24'h0); src = LVL; tick(3);
    rreg(3'd1, d); rreg(3'd1, d); chk("R8 level masked and read", {16'h0, d}, 24'h04);
    chk("R9 level masked no irq", {23'h0, irq}, 24'h0);
    src = '0; tick(3);
    rreg(3'd1, d); chk("R8 level released", {16'h0, d}, 24'h0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule